// File: doc/BRIEF.md
# Memory-mapped GPIO block with edge interrupts

This block drives and samples a bank of general-purpose lines (32 by default) through a small word-addressed register bus. Software sets each line's direction, can make an output line open-drain, writes output values and reads back line levels. Pin inputs cross into the clock domain through a two-flop synchroniser. An edge detector then records events in a sticky register. Each line picks either falling-edge-only or any-edge detection. A per-line mask gates the events onto one combined interrupt output.

Register bit `NLINES-1-k` belongs to line `k`, so line 0 is the most significant register bit. The pin vectors are indexed by line number. The register bus takes one access per cycle and is always ready; it never applies back-pressure. A write takes effect at the clock edge that samples it. A read returns its data in `bus_rdata` one cycle later, and `bus_rdata` then holds that value until the next read. The pin and interrupt side has no handshake: the lines are plain levels.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all zero, `pin_out` is all zero and `irq` is low.
- R2: Registers sit at byte addresses 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge select and 0x18 input enable. A write is visible from the next cycle. Read data appears one cycle after the request. Writes to 0x1C or to any address with bits [1:0] not zero are ignored, and reads of those addresses return 0.
- R3: Line k corresponds to register bit NLINES-1-k in every register, and to index k of `pin_in`, `pin_out` and `pin_oe`.
- R4: `pin_out[k]` equals the line's data bit. `pin_oe[k]` is 1 only when the line's direction bit is 1 (1 = output, 0 = input).
- R5: When a line has both direction and open-drain bits set, `pin_oe[k]` is 1 only while its data bit is 0.
- R6: A data read returns the written value for output lines. For input lines it returns the synchronised pin level when the input-enable bit is 1, and 0 when that bit is 0.
- R7: A pin change is sampled into the data readback two rising edges after it is applied. A qualifying edge sets its event bit at the third rising edge after it is applied, and no earlier.
- R8: An edge-select bit of 1 flags only falling edges on that line. A bit of 0 flags both rising and falling edges.
- R9: Writing the event register clears exactly the bits written as 1 and leaves the others.
- R10: When a new edge and a clear hit the same event bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when some event bit and its mask bit (1 = enabled) are both 1.
- R12: `bus_rdata` changes only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data, one cycle after the request |
| pin_in | input | NLINES | Pin levels, indexed by line |
| pin_out | output | NLINES | Output values, indexed by line |
| pin_oe | output | NLINES | Output enables, indexed by line |
| irq | output | 1 | Combined interrupt |

## Verification
Two things can happen to one event bit in the same cycle: a synchronised edge can set it while a bus write clears it. The bench sets this up by changing a pin and then timing an all-ones event write to land on the third rising edge, the edge where the event registers. A read of the event register afterwards must show that line still pending, while every other line has been cleared. A bound property also requires every detected edge to appear in the event register on the next cycle, whatever the bus is doing at the time.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SLOT_DIR = 3'd0,
    SLOT_ODR = 3'd1,
    SLOT_DAT = 3'd2,
    SLOT_EVT = 3'd3,
    SLOT_MSK = 3'd4,
    SLOT_ESEL = 3'd5,
    SLOT_IEN = 3'd6
  } reg_slot_e;

  localparam logic [2:0] LAST_SLOT = 3'd6;
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/gpio_ctrl_edge.sv
module gpio_ctrl_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] hit
);
  logic [W-1:0] last_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // a fall is last=1,lvl=0; a rise is only accepted when fall_only is clear
    assign hit[b] = (lvl[b] ^ last_q[b]) & (~fall_only[b] | last_q[b]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q[b] <= 1'b0;
        evt[b]    <= 1'b0;
      end else begin
        last_q[b] <= lvl[b];
        evt[b]    <= (evt[b] & ~clr[b]) | hit[b];
      end
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      odr,
  output logic [W-1:0]      dat,
  output logic [W-1:0]      msk,
  output logic [W-1:0]      esel,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      evt_clr
);
  logic       hit_ok;
  logic [2:0] slot;
  logic       wr_ok, rd_ok;
  logic [W-1:0] dat_view, rd_mux;

  assign slot   = bus_addr[ADDR_W-1:2];
  assign hit_ok = (bus_addr[1:0] == 2'b00) && (slot <= LAST_SLOT);
  assign wr_ok  = bus_sel && bus_we && hit_ok;
  assign rd_ok  = bus_sel && !bus_we;

  assign evt_clr  = (wr_ok && slot == SLOT_EVT) ? bus_wdata : '0;
  assign dat_view = (dat & dir) | (lvl & ien & ~dir);

  always_comb begin
    rd_mux = '0;
    if (hit_ok) begin
      case (slot)
        SLOT_DIR:  rd_mux = dir;
        SLOT_ODR:  rd_mux = odr;
        SLOT_DAT:  rd_mux = dat_view;
        SLOT_EVT:  rd_mux = evt;
        SLOT_MSK:  rd_mux = msk;
        SLOT_ESEL: rd_mux = esel;
        SLOT_IEN:  rd_mux = ien;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir  <= '0;
      odr  <= '0;
      dat  <= '0;
      msk  <= '0;
      esel <= '0;
      ien  <= '0;
    end else if (wr_ok) begin
      case (slot)
        SLOT_DIR:  dir  <= bus_wdata;
        SLOT_ODR:  odr  <= bus_wdata;
        SLOT_DAT:  dat  <= bus_wdata;
        SLOT_MSK:  msk  <= bus_wdata;
        SLOT_ESEL: esel <= bus_wdata;
        SLOT_IEN:  ien  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  logic [NLINES-1:0] pin_bits, lvl, oe_bits;
  logic [NLINES-1:0] dir_q, odr_q, dat_q, msk_q, esel_q, ien_q;
  logic [NLINES-1:0] evt_q, evt_clr, hit;

  // line k <-> register bit NLINES-1-k
  for (genvar k = 0; k < NLINES; k++) begin : g_swap
    assign pin_bits[NLINES-1-k] = pin_in[k];
    assign pin_out[k]           = dat_q[NLINES-1-k];
    assign pin_oe[k]            = oe_bits[NLINES-1-k];
  end

  gpio_ctrl_sync #(.W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_bits), .q(lvl)
  );

  gpio_ctrl_edge #(.W(NLINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .fall_only(esel_q),
    .clr(evt_clr), .evt(evt_q), .hit(hit)
  );

  gpio_ctrl_regs #(.W(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl), .evt(evt_q),
    .dir(dir_q), .odr(odr_q), .dat(dat_q), .msk(msk_q),
    .esel(esel_q), .ien(ien_q), .evt_clr(evt_clr)
  );

  // open-drain lines drive only a low level
  assign oe_bits = dir_q & ~(odr_q & dat_q);
  assign irq     = |(evt_q & msk_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_we,
  input logic [4:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] evt,
  input logic [W-1:0] hit,
  input logic [W-1:0] msk,
  input logic [W-1:0] dir,
  input logic [W-1:0] pin_oe,
  input logic         irq
);
  logic clr_wr;
  assign clr_wr = bus_sel && bus_we && (bus_addr == 5'h0C);

  for (genvar k = 0; k < W; k++) begin : g_line
    assert_oe_needs_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[k] |-> dir[W-1-k]);
  end

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((evt & $past(bus_wdata) & ~$past(hit)) == '0));

  assert_evt_from_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & ~$past(hit)) == '0));

  assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & ~evt) == '0));

  assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk != '0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.W(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt(evt_q), .hit(hit), .msk(msk_q), .dir(dir_q), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cur_pins = '0;
  // reference state, register-bit order
  logic [31:0] m_dir, m_odr, m_dat, m_evt, m_msk, m_esel, m_ien;
  logic [31:0] m_s1, m_s2, m_last, m_rd;

  always #4 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mread(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_dir;
      3'd1: return m_odr;
      3'd2: return (m_dat & m_dir) | (m_s2 & m_ien & ~m_dir);
      3'd3: return m_evt;
      3'd4: return m_msk;
      3'd5: return m_esel;
      3'd6: return m_ien;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mreset();
    m_dir = '0; m_odr = '0; m_dat = '0; m_evt = '0; m_msk = '0; m_esel = '0;
    m_ien = '0; m_s1 = '0; m_s2 = '0; m_last = '0; m_rd = '0;
  endtask

  task automatic step(input logic sel, input logic we, input logic [4:0] a,
                      input logic [31:0] wd, input logic [31:0] pins);
    logic [31:0] edges, clr;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; pin_in = pins;
    cur_pins = pins;
    edges = (m_s2 ^ m_last) & (~m_esel | m_last);
    clr = '0;
    if (sel && !we) m_rd = mread(a);
    if (sel && we && a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: m_dir = wd;
        3'd1: m_odr = wd;
        3'd2: m_dat = wd;
        3'd3: clr = wd;
        3'd4: m_msk = wd;
        3'd5: m_esel = wd;
        3'd6: m_ien = wd;
        default: ;
      endcase
    end
    m_evt = (m_evt & ~clr) | edges;
    m_last = m_s2; m_s2 = m_s1; m_s1 = rev(pins);
    @(negedge clk);
    chk("R4 pin_out", pin_out, rev(m_dat));
    chk("R5 pin_oe", pin_oe, rev(m_dir & ~(m_odr & m_dat)));
    chk("R11 irq", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
    if (sel && !we) chk((a == 5'h08) ? "R6 data read" : "R2 read", bus_rdata, m_rd);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, cur_pins);
  endtask
  task automatic rd(input logic [4:0] a);
    step(1'b1, 1'b0, a, 32'h0, cur_pins);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'h0, 32'h0, cur_pins);
  endtask
  task automatic setpins(input logic [31:0] p);
    step(1'b0, 1'b0, 5'h0, 32'h0, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 oe after reset", pin_oe, 32'h0);
    chk("R1 out after reset", pin_out, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4));
      chk("R1 register reads 0", bus_rdata, 32'h0);
    end

    // R3 bit order: register bits 31,30 are lines 0,1
    wr(5'h00, 32'hC000_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    chk("R3 oe lines 0,1", pin_oe, 32'h0000_0003);
    chk("R4 out all ones", pin_out, 32'hFFFF_FFFF);

    // R5 open-drain on line 1
    wr(5'h04, 32'h4000_0000);
    chk("R5 open-drain high releases", pin_oe, 32'h0000_0001);
    wr(5'h08, 32'h0000_0000);
    chk("R5 open-drain low drives", pin_oe, 32'h0000_0003);

    // R6 data readback mux, line 2 as input
    setpins(32'h0000_0004);
    idle(3);
    rd(5'h08);
    chk("R6 input buffer off reads 0", bus_rdata, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h08);
    chk("R6 input line level", bus_rdata, 32'h2000_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08);
    chk("R6 outputs return driven value", bus_rdata, 32'hE000_0000);

    // R7 event timing on line 3 (bit 28)
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h1000_0000);
    setpins(32'h0000_000C);
    chk("R7 no event after edge 1", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R7 no event after edge 2", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R7 event at edge 3", {31'b0, irq}, 32'h1);
    rd(5'h0C);
    chk("R7 event bit line 3", bus_rdata, 32'h1000_0000);

    // R8 falling-only on line 4 (bit 27)
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h14, 32'h0800_0000);
    wr(5'h10, 32'h0800_0000);
    setpins(32'h0000_001C);
    idle(4);
    chk("R8 rise ignored when falling-only", {31'b0, irq}, 32'h0);
    setpins(32'h0000_000C);
    idle(4);
    chk("R8 fall flagged", {31'b0, irq}, 32'h1);

    // R9 single-bit clear, lines 5 and 6
    wr(5'h0C, 32'hFFFF_FFFF);
    setpins(32'h0000_006C);
    idle(4);
    wr(5'h0C, 32'h0400_0000);
    rd(5'h0C);
    chk("R9 only written bit cleared", bus_rdata, 32'h0200_0000);

    // R10 edge and clear in the same cycle, line 7 (bit 24)
    wr(5'h0C, 32'hFFFF_FFFF);
    setpins(32'h0000_00EC);
    idle(1);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C);
    chk("R10 new edge survives clear", bus_rdata, 32'h0100_0000);

    // R2 unmapped and misaligned accesses
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'h0000_0000);
    rd(5'h00);
    chk("R2 direction untouched", bus_rdata, 32'hC000_0000);
    rd(5'h1C);
    chk("R2 unmapped reads 0", bus_rdata, 32'h0);
    rd(5'h05);
    chk("R2 misaligned reads 0", bus_rdata, 32'h0);

    // R12 read data holds
    rd(5'h00);
    held = bus_rdata;
    wr(5'h10, 32'h0);
    idle(3);
    chk("R12 rdata held", bus_rdata, held);

    // random traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] np;
      logic [4:0]  a;
      int op;
      np = cur_pins;
      if ($urandom % 4 == 0) np = np ^ (32'h1 << ($urandom % 32));
      op = $urandom % 8;
      a = 5'(($urandom % 8) * 4);
      if ($urandom % 10 == 0) a = a | 5'h2;
      if (op < 3)      step(1'b1, 1'b1, a, $urandom, np);
      else if (op < 6) step(1'b1, 1'b0, a, 32'h0, np);
      else             step(1'b0, 1'b0, 5'h0, 32'h0, np);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule